// File: doc/BRIEF.md
# Radix-4 Signed Carry-Save Array Multiplier

This block multiplies two W-bit two's-complement operands and returns their exact 2W-bit two's-complement product, with no clock and no state. Both operands are cut into m-bit digit groups (m = 2, so radix 4). Every pairing of a multiplicand group with a multiplier group is formed by a small digit cell. The cell kind follows from where the pair sits: both groups unsigned, one group signed (the most significant group of either operand), or both signed (the single corner cell). Cells that carry a sign have their top bit flipped. One constant bias row then accounts for all of them, so every row of the array has the same unsigned form.

The rows are folded by a linear chain of 3:2 carry-save compressors. Carry propagation happens only once, in a single ripple adder that merges the last sum and carry vectors. Any bits the bias or the carries push above bit 2W-1 are discarded. The block suits any datapath that needs a small, regular signed multiply and can afford one ripple chain on its critical path.

Top module: `rsm_mult`

## Requirements
- R1: For every pair of W-bit two's-complement operands, `p_o` equals the signed product `a_i * b_i` as a 2W-bit two's-complement value (checked over all 4096 pairs at W=6).
- R2: The output settles within the same time step as an operand change, with no clock edge involved: the block holds no state.
- R3: The corner case where both operands are the most negative value (-32 at W=6) yields +1024, which is 0x400 in 12 bits.
- R4: If either operand is zero, `p_o` is zero.
- R5: With `b_i` equal to +1, `p_o` is `a_i` sign-extended to 2W bits. The same holds with the roles swapped.
- R6: With `a_i` equal to -1 (all ones), `p_o` is the 2W-bit negation of `b_i` sign-extended.
- R7: When both operands are nonzero, bit 2W-1 of `p_o` equals the XOR of bit W-1 of the two operands.
- R8: Bits of the final addition at weight 2^(2W) and above, which come from the constant sign bias and from the carries, are dropped. As a result a positive × negative product such as 31 × -32 = -992 reads 0xC20 and not a wider value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, two's complement |
| b_i | input | W | Multiplier, two's complement |
| p_o | output | 2W | Product, two's complement |

## Verification
The hardest situation to reach is the one where the signed corner cell, the flipped sign bits and the bias row must cancel exactly. That happens when both top digit groups are negative and their magnitudes are large, for instance -32 × -32, where a single wrong bias bit shows up only as an overflow in the top bits. The bench sweeps every operand pair at W=6, so every combination of cell signs is reached. It also names the extreme corner, the sign boundary and the operand identities as separate checks.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    // Cell kind: which of the two digit groups is interpreted as signed.
    typedef enum logic [1:0] {
        CK_UU = 2'd0,   // both groups unsigned
        CK_SA = 2'd1,   // multiplicand group signed, multiplier group unsigned
        CK_SB = 2'd2,   // multiplicand group unsigned, multiplier group signed
        CK_SS = 2'd3    // both groups signed (the single corner cell)
    } cell_kind_e;

    // Kind of the cell pairing multiplicand group ia with multiplier group ib
    // in an array of ng x ng groups: the top group of an operand is signed.
    function automatic cell_kind_e kind_of(input int ia, input int ib, input int ng);
        if (ia == ng - 1 && ib == ng - 1) return CK_SS;
        if (ia == ng - 1)                 return CK_SA;
        if (ib == ng - 1)                 return CK_SB;
        return CK_UU;
    endfunction

    function automatic bit kind_is_signed(input cell_kind_e k);
        return k != CK_UU;
    endfunction

endpackage

// File: rtl/rsm_digit_cell.sv
module rsm_digit_cell #(
    parameter int                  M    = 2,
    parameter rsm_pkg::cell_kind_e KIND = rsm_pkg::CK_UU
) (
    input  logic [M-1:0]   a_dig_i,
    input  logic [M-1:0]   b_dig_i,
    output logic [2*M-1:0] pp_o
);
    localparam int PW = 2 * M;

    typedef struct packed {
        logic signed [M:0]    ax;
        logic signed [M:0]    bx;
        logic signed [PW+1:0] prod;
        logic [PW-1:0]        raw;
        logic [PW-1:0]        pp;
    } cell_state_t;

    cell_state_t cell_d;

    always_comb begin
        cell_d = '0;
        // Widen each group by one bit, sign or zero, according to the kind.
        if (KIND == rsm_pkg::CK_SA || KIND == rsm_pkg::CK_SS)
            cell_d.ax = {a_dig_i[M-1], a_dig_i};
        else
            cell_d.ax = {1'b0, a_dig_i};
        if (KIND == rsm_pkg::CK_SB || KIND == rsm_pkg::CK_SS)
            cell_d.bx = {b_dig_i[M-1], b_dig_i};
        else
            cell_d.bx = {1'b0, b_dig_i};
        cell_d.prod = cell_d.ax * cell_d.bx;
        cell_d.raw  = cell_d.prod[PW-1:0];
        // Signed results get their top bit flipped: the value becomes
        // unsigned and is offset by +2^(PW-1), removed later by the bias row.
        if (rsm_pkg::kind_is_signed(KIND))
            cell_d.pp = {~cell_d.raw[PW-1], cell_d.raw[PW-2:0]};
        else
            cell_d.pp = cell_d.raw;
    end

    assign pp_o = cell_d.pp;

endmodule

// File: rtl/rsm_csa.sv
module rsm_csa #(
    parameter int N = 12
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    input  logic [N-1:0] z_i,
    output logic [N-1:0] sum_o,
    output logic [N-1:0] car_o
);
    typedef struct packed {
        logic [N-1:0] sum;
        logic [N-2:0] maj;
    } csa_state_t;

    csa_state_t csa_d;

    always_comb begin
        csa_d.sum = x_i ^ y_i ^ z_i;
        // The majority at the top position would land above the word and is not formed.
        csa_d.maj = (x_i[N-2:0] & y_i[N-2:0]) |
                    (x_i[N-2:0] & z_i[N-2:0]) |
                    (y_i[N-2:0] & z_i[N-2:0]);
    end

    assign sum_o = csa_d.sum;
    assign car_o = {csa_d.maj, 1'b0};

endmodule

// File: rtl/rsm_ripple.sv
module rsm_ripple #(
    parameter int N = 12
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    output logic [N-1:0] s_o
);
    logic [N-1:0] cy_w;

    assign cy_w[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_fa
        assign s_o[k] = x_i[k] ^ y_i[k] ^ cy_w[k];
        if (k < N - 1) begin : g_cy
            assign cy_w[k+1] = (x_i[k] & y_i[k]) | (cy_w[k] & (x_i[k] ^ y_i[k]));
        end
    end

endmodule

// File: rtl/rsm_mult.sv
module rsm_mult #(
    parameter int W = 6,
    parameter int M = 2
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] p_o
);
    localparam int G  = W / M;        // digit groups per operand
    localparam int NC = G * G;        // digit cells
    localparam int R  = NC + 1;       // rows including the bias row
    localparam int NW = 2 * W;        // array width
    localparam int PW = 2 * M;        // cell output width

    // Sum of the offsets introduced by flipping the top bit of every
    // signed cell, negated modulo 2^NW.
    function automatic logic [NW-1:0] calc_bias();
        logic [NW-1:0] acc;
        acc = '0;
        for (int ia = 0; ia < G; ia++) begin
            for (int ib = 0; ib < G; ib++) begin
                if (rsm_pkg::kind_is_signed(rsm_pkg::kind_of(ia, ib, G)))
                    acc = acc - (NW'(1) << (M * (ia + ib) + PW - 1));
            end
        end
        return acc;
    endfunction

    localparam logic [NW-1:0] BIAS = calc_bias();

    typedef struct packed {
        logic [R-1:0][NW-1:0] rows;
    } row_set_t;

    logic [PW-1:0] pp_w [NC];
    row_set_t      row_d;

    // Digit cells, kind chosen by position.
    for (genvar ia = 0; ia < G; ia++) begin : g_ca
        for (genvar ib = 0; ib < G; ib++) begin : g_cb
            localparam rsm_pkg::cell_kind_e CK = rsm_pkg::kind_of(ia, ib, G);
            rsm_digit_cell #(.M(M), .KIND(CK)) u_cell (
                .a_dig_i (a_i[M*ia +: M]),
                .b_dig_i (b_i[M*ib +: M]),
                .pp_o    (pp_w[ia*G + ib])
            );
        end
    end

    // Place every cell result at its weight; last row is the constant bias.
    always_comb begin
        row_d = '0;
        for (int ia = 0; ia < G; ia++) begin
            for (int ib = 0; ib < G; ib++) begin
                row_d.rows[ia*G + ib] = {{(NW-PW){1'b0}}, pp_w[ia*G + ib]} << (M * (ia + ib));
            end
        end
        row_d.rows[R-1] = BIAS;
    end

    // Linear carry-save chain: stage k folds row k+2 into the running pair.
    logic [NW-1:0] st_sum [R-2];
    logic [NW-1:0] st_car [R-2];

    for (genvar k = 0; k < R - 2; k++) begin : g_st
        if (k == 0) begin : g_first
            rsm_csa #(.N(NW)) u_csa (
                .x_i   (row_d.rows[0]),
                .y_i   (row_d.rows[1]),
                .z_i   (row_d.rows[2]),
                .sum_o (st_sum[0]),
                .car_o (st_car[0])
            );
        end else begin : g_next
            rsm_csa #(.N(NW)) u_csa (
                .x_i   (st_sum[k-1]),
                .y_i   (st_car[k-1]),
                .z_i   (row_d.rows[k+2]),
                .sum_o (st_sum[k]),
                .car_o (st_car[k])
            );
        end
    end

    // Single carry-propagate merge; weights from 2^NW up are dropped.
    rsm_ripple #(.N(NW)) u_merge (
        .x_i (st_sum[R-3]),
        .y_i (st_car[R-3]),
        .s_o (p_o)
    );

endmodule

// File: rtl/rsm_mult_chk.sv
module rsm_mult_chk #(
    parameter int W = 6
) (
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic [2*W-1:0] p_o
);
    logic signed [2*W-1:0] ref_w;
    logic signed [2*W-1:0] a_ext_w;
    logic signed [2*W-1:0] b_ext_w;

    always_comb begin
        ref_w   = $signed(a_i) * $signed(b_i);
        a_ext_w = (2*W)'($signed(a_i));
        b_ext_w = (2*W)'($signed(b_i));
        assert_exact_product_R1: assert (p_o == ref_w)
            else $error("R1 product mismatch");
        assert_zero_operand_R4: assert (!((a_i == '0) || (b_i == '0)) || (p_o == '0))
            else $error("R4 zero operand");
        assert_unit_multiplier_R5: assert (!(b_i == W'(1)) || (p_o == a_ext_w))
            else $error("R5 unit multiplier");
        assert_negate_R6: assert (!(a_i == '1) || (p_o == -b_ext_w))
            else $error("R6 negation");
        assert_sign_R7: assert (!((a_i != '0) && (b_i != '0)) ||
                                (p_o[2*W-1] == (a_i[W-1] ^ b_i[W-1])))
            else $error("R7 product sign");
        assert_corner_R3: assert (!((a_i == {1'b1, {(W-1){1'b0}}}) && (b_i == {1'b1, {(W-1){1'b0}}})) ||
                                  (p_o == ((2*W)'(1) << (2*W-2))))
            else $error("R3 corner");
    end

endmodule

bind rsm_mult rsm_mult_chk #(.W(W)) u_chk (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p_o)
);

// File: tb/tb_rsm_mult.sv
module tb_rsm_mult;
    localparam int W  = 6;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic [W-1:0]  a_s = '0;
    logic [W-1:0]  b_s = '0;
    logic [PW-1:0] p_w;
    int            n_run  = 0;
    int            n_fail = 0;
    int            cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    rsm_mult #(.W(W), .M(2)) dut (
        .a_i (a_s),
        .b_i (b_s),
        .p_o (p_w)
    );

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, $signed(a_s), $signed(b_s), act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        a_s = a;
        b_s = b;
        #1;
    endtask

    function automatic logic [PW-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        int pa, pb;
        pa = $signed(a);
        pb = $signed(b);
        return PW'(pa * pb);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: operands zero, product zero (R4).
        #1;
        check("R4 reset", p_w, '0);

        // R2: combinational response, no clock edge between change and sample.
        @(posedge clk);
        #0.5;
        a_s = 6'd5;
        b_s = 6'd7;
        #0.5;
        check("R2 same-step", p_w, 12'd35);

        // R3: most negative squared.
        apply(6'b100000, 6'b100000);
        check("R3 corner", p_w, 12'h400);

        // R8: top bits dropped on positive x negative extreme.
        apply(6'd31, 6'b100000);
        check("R8 drop", p_w, 12'hC20);
        apply(6'd31, 6'd31);
        check("R8 max pos", p_w, 12'd961);

        // R4: zero operand.
        apply(6'b100000, 6'd0);
        check("R4 zero b", p_w, '0);
        apply(6'd0, 6'b101011);
        check("R4 zero a", p_w, '0);

        // R5: unity.
        apply(6'b110011, 6'd1);
        check("R5 unit b", p_w, 12'hFF3);
        apply(6'd1, 6'd27);
        check("R5 unit a", p_w, 12'd27);

        // R6: negation.
        apply(6'b111111, 6'd17);
        check("R6 neg", p_w, 12'hFEF);
        apply(6'b111111, 6'b100000);
        check("R6 neg min", p_w, 12'd32);

        // R7: sign boundary.
        apply(6'b111111, 6'd1);
        check("R7 sign", {11'd0, p_w[PW-1]}, 12'd1);

        // R1: exhaustive sweep.
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                apply(W'(ia), W'(ib));
                check("R1 sweep", p_w, model(W'(ia), W'(ib)));
                if (ia != 0 && ib != 0)
                    check("R7 sweep", {11'd0, p_w[PW-1]},
                          {11'd0, W'(ia) >> (W-1) ^ W'(ib) >> (W-1)} & 12'd1);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule